// File: doc/BRIEF.md
# Maskable Interrupt Aggregation Controller

This block gathers single-cycle event pulses from on-chip detectors, such as level monitors or conversion-done flags, and turns them into one external interrupt line. Each event source has a sticky status bit. The host reads the status bits to learn which sources fired, and clears them by writing ones. A host-side synchronous register port gives access to three registers: status, mask and output polarity.

A set mask bit turns off detection for its source. It does not just hide the output of that source. An event that arrives while its source is masked is dropped for good. A status bit that was already set when its source was masked stays set until the host clears it. While the source is masked, that bit does not drive the line. The line idles high and is active low after reset. A polarity bit can make it active high.

Register map (address: contents):
- Address 0: status. Write 1 to clear a bit.
- Address 1: mask.
- Address 2: polarity in bit 0.
- Address 3: reads as zero.

Top module: `irq_agg`

## Requirements
- R1: After reset, status, mask and polarity all read as zero, and `irq_o` is high (inactive).
- R2: An event pulse on an unmasked source sets its status bit in the next cycle, and address 0 reads it back. Bit i belongs to source i.
- R3: Writing to address 0 clears every status bit whose write-data bit is 1. Bits written with 0 keep their value.
- R4: If an unmasked event and a clear of the same bit occur in the same cycle, the bit ends up set.
- R5: An event on a source whose mask bit is 1 is not recorded. The event does not appear in status after the mask is cleared.
- R6: Setting a mask bit leaves an already-set status bit set until the host clears it. New events on that masked source have no effect.
- R7: The line is asserted exactly when some source has its status bit at 1 and its mask bit at 0. A pending status bit that is masked does not hold the line asserted.
- R8: Bit 0 of address 2 selects polarity: 0 gives an active-low line, 1 gives an active-high line. Bits 7 to 1 of address 2 read as zero.
- R9: Address 1 reads back the last mask value written. Reads of address 3 return zero. A write to address 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NSRC | Event pulses, one per source, sampled each rising edge |
| reg_addr | input | 2 | Register address |
| reg_we | input | 1 | Write enable |
| reg_wdata | input | NSRC | Write data |
| reg_rdata | output | NSRC | Read data for `reg_addr` (combinational) |
| irq_o | output | 1 | Combined interrupt line |

## Verification
The assertions assume that `evt_i` and the register inputs are stable around each rising edge. They also assume that a mask write takes effect from the following cycle, so an event and a mask write in the same cycle see the old mask. The bench drives all inputs on the falling edge and samples outputs just after it. Random stimulus covers any mix of events, writes and addresses, including a clear of a bit in the same cycle as an event on it, and a mask write in the same cycle as an event on the masked source. The bench's reference model applies the same old-mask rule in those cycles.

// File: rtl/irq_agg.sv
module irq_agg #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_i,
  input  logic [1:0]      reg_addr,
  input  logic            reg_we,
  input  logic [NSRC-1:0] reg_wdata,
  output logic [NSRC-1:0] reg_rdata,
  output logic            irq_o
);
  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_MASK = 2'd1;
  localparam logic [1:0] A_POL  = 2'd2;

  logic [NSRC-1:0] status_q, mask_q, clr, captured;
  logic            pol_q, pending;

  assign clr      = (reg_we && reg_addr == A_STAT) ? reg_wdata : '0;
  assign captured = evt_i & ~mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
      pol_q    <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr) | captured;
      if (reg_we && reg_addr == A_MASK) mask_q <= reg_wdata;
      if (reg_we && reg_addr == A_POL)  pol_q  <= reg_wdata[0];
    end
  end

  assign pending = |(status_q & ~mask_q);
  assign irq_o   = pol_q ? pending : ~pending;

  always_comb begin
    case (reg_addr)
      A_STAT:  reg_rdata = status_q;
      A_MASK:  reg_rdata = mask_q;
      A_POL:   reg_rdata = {{(NSRC-1){1'b0}}, pol_q};
      default: reg_rdata = '0;
    endcase
  end

  // R5
  masked_no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & $past(mask_q)) == '0));

  // R4
  event_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(evt_i & ~mask_q)) == $past(evt_i & ~mask_q)));

  // R3
  sticky_until_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status_q) & ~$past(clr) & ~status_q) == '0));

  // R7
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~mask_q) == '0) |-> (irq_o == !pol_q));

  // R8
  pol_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_POL) |-> (reg_rdata[NSRC-1:1] == '0));
endmodule

// File: tb/irq_agg_tb.sv
module irq_agg_tb;
  localparam int N = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] evt_i = '0, reg_wdata = '0, reg_rdata;
  logic [1:0] reg_addr = '0;
  logic reg_we = 1'b0, irq_o;

  int n_run = 0, n_fail = 0;
  logic [N-1:0] m_stat = '0, m_mask = '0;
  logic m_pol = 1'b0;

  always #10 clk = ~clk;

  irq_agg #(.NSRC(N)) u_dut (.clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o));

  function automatic logic exp_irq();
    logic p = |(m_stat & ~m_mask);
    return m_pol ? p : ~p;
  endfunction

  function automatic logic [N-1:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return m_stat;
      2'd1: return m_mask;
      2'd2: return {{(N-1){1'b0}}, m_pol};
      default: return '0;
    endcase
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic cyc(input logic [N-1:0] e, input logic we, input logic [1:0] a, input logic [N-1:0] d);
    logic [N-1:0] clr;
    evt_i = e; reg_we = we; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    clr = (we && a == 2'd0) ? d : '0;
    m_stat = (m_stat & ~clr) | (e & ~m_mask);
    if (we && a == 2'd1) m_mask = d;
    if (we && a == 2'd2) m_pol = d[0];
    @(negedge clk);
    evt_i = '0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [N-1:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  logic [N-1:0] v;

  initial begin
    #(200000 * 20);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", irq_o, 1);
    rd(0, v); chk("R1 status", v, 0);
    rd(1, v); chk("R1 mask", v, 0);
    rd(2, v); chk("R1 pol", v, 0);
    // R2 capture
    cyc(8'h01, 0, 0, 0);
    rd(0, v); chk("R2 status", v, 8'h01);
    chk("R7 asserted low", irq_o, 0);
    // R3 write zero keeps, write one clears
    cyc(0, 1, 0, 8'h00); rd(0, v); chk("R3 zero write", v, 8'h01);
    cyc(0, 1, 0, 8'h01); rd(0, v); chk("R3 clear", v, 8'h00);
    chk("R7 released", irq_o, 1);
    // R4 event wins over clear
    cyc(8'h02, 0, 0, 0);
    cyc(8'h02, 1, 0, 8'h02); rd(0, v); chk("R4 event wins", v, 8'h02);
    cyc(0, 1, 0, 8'hFF);
    // R5 masked event dropped
    cyc(0, 1, 1, 8'h04);
    cyc(8'h04, 0, 0, 0); rd(0, v); chk("R5 masked", v, 0);
    chk("R5 irq", irq_o, 1);
    cyc(0, 1, 1, 8'h00); rd(0, v); chk("R5 after unmask", v, 0);
    // R6 mask after trigger
    cyc(8'h08, 0, 0, 0); chk("R7 pending", irq_o, 0);
    cyc(0, 1, 1, 8'h08); rd(0, v); chk("R6 stays set", v, 8'h08);
    chk("R7 masked pending", irq_o, 1);
    cyc(8'h08, 0, 0, 0); chk("R6 no retrigger", irq_o, 1);
    cyc(0, 1, 1, 8'h00); chk("R7 unmask pending", irq_o, 0);
    cyc(0, 1, 0, 8'hFF);
    // R8 polarity
    cyc(0, 1, 2, 8'hFF); rd(2, v); chk("R8 pol read", v, 8'h01);
    chk("R8 idle high-active", irq_o, 0);
    cyc(8'h80, 0, 0, 0); chk("R8 active high", irq_o, 1);
    cyc(0, 1, 0, 8'h80); cyc(0, 1, 2, 8'h00);
    chk("R8 back to low", irq_o, 1);
    // R9 mask readback and unused address
    cyc(0, 1, 1, 8'h5A); rd(1, v); chk("R9 mask rd", v, 8'h5A);
    cyc(0, 1, 3, 8'hFF); rd(3, v); chk("R9 unused", v, 0);
    rd(1, v); chk("R9 mask kept", v, 8'h5A);
    rd(0, v); chk("R9 status kept", v, 0);
    rd(2, v); chk("R9 pol kept", v, 0);
    cyc(0, 1, 1, 8'h00);
    // random
    void'($urandom(32'd1234));
    for (int i = 0; i < 2000; i++) begin
      logic [N-1:0] e, d;
      logic we;
      logic [1:0] a;
      e = N'($urandom) & N'($urandom) & N'($urandom);
      we = ($urandom % 4) == 0;
      a = 2'($urandom);
      d = N'($urandom);
      cyc(e, we, a, d);
      chk("R7 random irq", irq_o, exp_irq());
      a = 2'($urandom);
      rd(a, v);
      chk(a == 0 ? "R2 random status" : a == 1 ? "R9 random mask" :
          a == 2 ? "R8 random pol" : "R9 random unused", v, exp_rd(a));
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule